// File: doc/BRIEF.md
# Shortened Punctured Reed-Solomon Syndrome Calculator

This block evaluates the sixteen syndromes of a received frame protected by a byte-wide Reed-Solomon code with sixteen parity symbols. The frame has been shortened and punctured, so the receiver sees fewer bytes than the full 255-symbol word. A rate identifier sampled at frame start selects the received length and the number of parity positions that were never transmitted. The leading data positions are known to be zero, so they are never fed in. Evaluation starts with the first received byte.

Bytes enter one per cycle under a valid strobe. After the last received byte the block runs one extra accumulation step per punctured position, with a zero symbol. It then pulses `done_o` and holds the syndrome vector until the consumer acknowledges it. A later decoding stage uses the vector and the errors flag to decide whether any correction is needed.

Top module: `rs_synd_calc`

## Requirements
- R1: After reset, `done_o` and `err_o` are low and every syndrome byte is zero.
- R2: Syndrome i sits at `syndromes_o[8i+7:8i]` for i = 0..15. It equals the XOR over received bytes r_j of r_j·α^(i·d_j) in GF(2^8), with field polynomial 0x11D and α = 0x02. d_j is the byte's degree.
- R3: Each rate id sets (bytes received, punctured count): 0 → (32,8), 1 → (40,12), 2 → (64,0), 3 → (80,8), 4 → (108,4), 5 → (120,4). The first received byte has degree n+B−1 and the last has degree B.
- R4: `done_o` rises at the B-th clock edge after the edge that accepts the last byte, or at that same edge when B = 0.
- R5: `done_o` is high for exactly one cycle per frame.
- R6: While a result is held, `err_o` is high exactly when some syndrome is nonzero.
- R7: Cycles with `data_valid_i` low do not advance the frame. Valid bytes outside a frame do not change the syndromes.
- R8: While a result waits for `ack_i`, `rdy_i` and data are ignored and the syndromes stay stable.
- R9: A `rdy_i` with rate id 6 or 7 starts no frame.
- R10: Every accepted frame start clears the syndromes, so a result never depends on earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rdy_i | input | 1 | Frame start strobe, taken when idle |
| rate_id_i | input | 3 | Rate selector, sampled with `rdy_i` |
| data_valid_i | input | 1 | Received byte strobe |
| data_i | input | 8 | Received byte |
| ack_i | input | 1 | Consumer has taken the result |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Some held syndrome is nonzero |
| syndromes_o | output | 128 | Sixteen syndrome bytes, S0 in the low byte |

## Verification
The properties assume that `rate_id_i` is meaningful whenever `rdy_i` is high, and that the result leaves only through `ack_i`. They do not assume that `ack_i` or `rdy_i` are single-cycle pulses. The bench changes every input only on the falling edge. It uses one-cycle strobes and sends exactly the number of valid bytes that the chosen rate calls for. It also deliberately sends out-of-protocol stimulus: starts during a held result, illegal rate ids, and strobes outside a frame. This exercises the ignore paths without breaking those assumptions.

// File: rtl/rs_synd_pkg.sv
package rs_synd_pkg;
  localparam int SYM_W  = 8;
  localparam int NSYN   = 16;
  localparam int RATE_W = 3;
  localparam int CNT_W  = 7;
  localparam logic [SYM_W-1:0] POLY_LO = 8'h1D;  // x^8 folded back

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p, x;
    p = '0;
    x = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? POLY_LO : '0);
    end
    return p;
  endfunction

  function automatic logic [SYM_W-1:0] gf_alpha_pow(input int e);
    logic [SYM_W-1:0] r;
    r = 8'h01;
    for (int k = 0; k < e; k++) r = gf_mul(r, 8'h02);
    return r;
  endfunction
endpackage

// File: rtl/rs_synd_rate_tab.sv
module rs_synd_rate_tab
  import rs_synd_pkg::*;
(
  input  logic [RATE_W-1:0] rate_i,
  output logic [CNT_W-1:0]  len_o,
  output logic [CNT_W-1:0]  pad_o,
  output logic              ok_o
);
  always_comb begin
    ok_o  = 1'b1;
    len_o = '0;
    pad_o = '0;
    unique case (rate_i)
      3'd0: begin len_o = 7'd32;  pad_o = 7'd8;  end
      3'd1: begin len_o = 7'd40;  pad_o = 7'd12; end
      3'd2: begin len_o = 7'd64;  pad_o = 7'd0;  end
      3'd3: begin len_o = 7'd80;  pad_o = 7'd8;  end
      3'd4: begin len_o = 7'd108; pad_o = 7'd4;  end
      3'd5: begin len_o = 7'd120; pad_o = 7'd4;  end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rs_synd_cell.sv
module rs_synd_cell
  import rs_synd_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] s_o
);
  localparam logic [SYM_W-1:0] ROOT = gf_alpha_pow(IDX);

  logic [SYM_W-1:0] s_q;

  // Horner step: S <- S*alpha^IDX + r
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= '0;
    else if (clr_i) s_q <= '0;
    else if (en_i)  s_q <= gf_mul(s_q, ROOT) ^ sym_i;
  end

  assign s_o = s_q;
endmodule

// File: rtl/rs_synd_ctrl.sv
module rs_synd_ctrl
  import rs_synd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rdy_i,
  input  logic             ok_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] pad_i,
  input  logic             valid_i,
  input  logic             ack_i,
  output logic             clr_o,
  output logic             step_o,
  output logic             zero_o,
  output logic             done_o,
  output logic             hold_o,
  output logic             idle_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_PAD, ST_HOLD} state_e;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q, len_q, pad_q;
  logic             done_q;

  assign idle_o = (state_q == ST_IDLE);
  assign hold_o = (state_q == ST_HOLD);
  assign clr_o  = idle_o && rdy_i && ok_i;
  assign zero_o = (state_q == ST_PAD);
  assign step_o = ((state_q == ST_RECV) && valid_i) || zero_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      pad_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (clr_o) begin
          len_q   <= len_i;
          pad_q   <= pad_i;
          cnt_q   <= '0;
          state_q <= ST_RECV;
        end
        ST_RECV: if (valid_i) begin
          if (cnt_q == len_q - 7'd1) begin
            cnt_q <= '0;
            if (pad_q == '0) begin
              state_q <= ST_HOLD;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_PAD;
            end
          end else begin
            cnt_q <= cnt_q + 7'd1;
          end
        end
        ST_PAD: begin
          if (cnt_q == pad_q - 7'd1) begin
            state_q <= ST_HOLD;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 7'd1;
          end
        end
        ST_HOLD: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_synd_calc.sv
module rs_synd_calc
  import rs_synd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rdy_i,
  input  logic [RATE_W-1:0]     rate_id_i,
  input  logic                  data_valid_i,
  input  logic [SYM_W-1:0]      data_i,
  input  logic                  ack_i,
  output logic                  done_o,
  output logic                  err_o,
  output logic [NSYN*SYM_W-1:0] syndromes_o
);
  logic [CNT_W-1:0] len_w, pad_w;
  logic             ok_w, clr_w, step_w, zero_w, hold_w, idle_w;
  logic [SYM_W-1:0] sym_w;

  rs_synd_rate_tab u_tab (
    .rate_i(rate_id_i),
    .len_o (len_w),
    .pad_o (pad_w),
    .ok_o  (ok_w)
  );

  rs_synd_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_i  (rdy_i),
    .ok_i   (ok_w),
    .len_i  (len_w),
    .pad_i  (pad_w),
    .valid_i(data_valid_i),
    .ack_i  (ack_i),
    .clr_o  (clr_w),
    .step_o (step_w),
    .zero_o (zero_w),
    .done_o (done_o),
    .hold_o (hold_w),
    .idle_o (idle_w)
  );

  // punctured positions enter as zero symbols
  assign sym_w = zero_w ? '0 : data_i;

  for (genvar g = 0; g < NSYN; g++) begin : g_cell
    rs_synd_cell #(.IDX(g)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_w),
      .en_i  (step_w),
      .sym_i (sym_w),
      .s_o   (syndromes_o[g*SYM_W +: SYM_W])
    );
  end

  assign err_o = hold_w && (syndromes_o != '0);
endmodule

// File: rtl/rs_synd_calc_chk.sv
module rs_synd_calc_chk
  import rs_synd_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rdy_i,
  input logic [RATE_W-1:0]     rate_id_i,
  input logic                  ack_i,
  input logic                  done_o,
  input logic                  hold_i,
  input logic                  idle_i,
  input logic [NSYN*SYM_W-1:0] syndromes_o
);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_in_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hold_i);

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !ack_i |=> hold_i && $stable(syndromes_o));

  assert_bad_rate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && rdy_i && (rate_id_i > 3'd5) |=> idle_i);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && !rdy_i |=> $stable(syndromes_o));
endmodule

bind rs_synd_calc rs_synd_calc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rdy_i      (rdy_i),
  .rate_id_i  (rate_id_i),
  .ack_i      (ack_i),
  .done_o     (done_o),
  .hold_i     (hold_w),
  .idle_i     (idle_w),
  .syndromes_o(syndromes_o)
);

// File: tb/rs_synd_calc_tb_top.sv
`timescale 1ns/1ps
module rs_synd_calc_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rdy = 1'b0;
  logic [2:0]   rate = '0;
  logic         valid = 1'b0;
  logic [7:0]   data = '0;
  logic         ack = 1'b0;
  logic         done, err;
  logic [127:0] synd;

  int n_chk = 0, n_bad = 0;
  logic [7:0]   rx [0:127];
  logic [127:0] exp_s, saved;
  int           k_done;
  bit           saw_done;

  always #5 clk = ~clk;

  rs_synd_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rdy_i(rdy), .rate_id_i(rate),
    .data_valid_i(valid), .data_i(data), .ack_i(ack),
    .done_o(done), .err_o(err), .syndromes_o(synd)
  );

  // stimulus table: {rate, kind, pos, val, seed, gap}
  // kind 0 zero frame, 1 single byte at pos, 2 pseudo-random
  localparam int NV = 8;
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'd0, 8'd0, 8'd0,   8'h00, 8'd0,    8'd0},
    {8'd1, 8'd1, 8'd0,   8'h55, 8'd0,    8'd0},
    {8'd2, 8'd1, 8'd63,  8'h01, 8'd0,    8'd1},
    {8'd3, 8'd2, 8'd0,   8'h00, 8'd3,    8'd0},
    {8'd4, 8'd1, 8'd107, 8'h80, 8'd0,    8'd0},
    {8'd5, 8'd2, 8'd0,   8'h00, 8'd9,    8'd1},
    {8'd0, 8'd1, 8'd31,  8'h07, 8'd0,    8'd0},
    {8'd3, 8'd2, 8'd0,   8'h00, 8'h5b,   8'd1}
  };

  function automatic int len_of(input int r);
    case (r) 0: return 32; 1: return 40; 2: return 64;
             3: return 80; 4: return 108; default: return 120; endcase
  endfunction
  function automatic int pad_of(input int r);
    case (r) 0: return 8; 1: return 12; 2: return 0;
             3: return 8; default: return 4; endcase
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
  endfunction
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int k = 7; k >= 0; k--) p = xt(p) ^ (b[k] ? a : 8'h00);
    return p;
  endfunction
  function automatic logic [7:0] m_pow(input int e);
    logic [7:0] r = 8'h01;
    for (int k = 0; k < (e % 255); k++) r = xt(r);
    return r;
  endfunction

  task automatic model(input int r);
    int n = len_of(r), b = pad_of(r);
    exp_s = '0;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < n; j++)
        exp_s[i*8 +: 8] ^= m_mul(rx[j], m_pow(i * (n + b - 1 - j)));
  endtask

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic start(input int r);
    @(negedge clk); rdy = 1'b1; rate = 3'(r);
    @(posedge clk);
    @(negedge clk); rdy = 1'b0;
  endtask

  // send bytes already in rx; measures edges from last byte to done
  task automatic send(input int n, input bit gap);
    for (int j = 0; j < n; j++) begin
      if (gap && (j % 5 == 2)) begin
        valid = 1'b0; data = 8'hFF;
        @(posedge clk); @(negedge clk);
      end
      valid = 1'b1; data = rx[j];
      @(posedge clk); @(negedge clk);
    end
    valid = 1'b0; data = 8'h00;
    k_done = 0;
    while (!done && k_done < 300) begin
      @(posedge clk); k_done++; @(negedge clk);
    end
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(posedge clk);
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !err && synd == '0, "R1", {126'd0, done, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < NV; t++) begin
      int r   = int'(VEC[t][47:40]);
      int knd = int'(VEC[t][39:32]);
      int n   = len_of(r);
      for (int j = 0; j < n; j++) begin
        if (knd == 0) rx[j] = 8'h00;
        else if (knd == 1) rx[j] = (j == int'(VEC[t][31:24])) ? VEC[t][23:16] : 8'h00;
        else rx[j] = 8'((j * int'(VEC[t][15:8]) * 7 + j * j + 1) & 255);
      end
      model(r);
      start(r);
      send(n, VEC[t][0]);
      // R2 R3 R7 R10 syndrome values
      check(synd == exp_s, "R2/R3", synd, exp_s);
      // R4 done timing
      check(k_done == pad_of(r), "R4", 128'(k_done), 128'(pad_of(r)));
      // R6 errors flag
      check(err == (exp_s != '0), "R6", {127'd0, err}, {127'd0, exp_s != '0});
      @(posedge clk); @(negedge clk);
      // R5 single-cycle pulse
      check(!done, "R5", {127'd0, done}, '0);
      do_ack();
    end

    // R8: start and bytes ignored while result held
    for (int j = 0; j < 32; j++) rx[j] = 8'(j + 1);
    model(0);
    start(0);
    send(32, 1'b0);
    saved = synd;
    @(negedge clk); rdy = 1'b1; rate = 3'd2;
    @(posedge clk); @(negedge clk); rdy = 1'b0;
    saw_done = 1'b0;
    for (int j = 0; j < 70; j++) begin
      valid = 1'b1; data = 8'hA5;
      @(posedge clk); @(negedge clk);
      if (done) saw_done = 1'b1;
    end
    valid = 1'b0;
    repeat (10) begin @(posedge clk); @(negedge clk); if (done) saw_done = 1'b1; end
    check(synd == saved && synd == exp_s, "R8", synd, saved);
    check(!saw_done, "R8", {127'd0, saw_done}, '0);
    check(err == 1'b1, "R6", {127'd0, err}, 128'd1);
    do_ack();
    // R6 flag low once result released
    check(!err, "R6", {127'd0, err}, '0);

    // R9: illegal rate ids; R7: valid bytes outside a frame
    for (int bad = 6; bad < 8; bad++) begin
      start(bad);
      saw_done = 1'b0;
      for (int j = 0; j < 130; j++) begin
        valid = 1'b1; data = 8'h3C;
        @(posedge clk); @(negedge clk);
        if (done) saw_done = 1'b1;
      end
      valid = 1'b0;
      check(synd == saved, "R9/R7", synd, saved);
      check(!saw_done, "R9", {127'd0, saw_done}, '0);
    end

    // R10: fresh zero frame after nonzero history clears to zero
    for (int j = 0; j < 64; j++) rx[j] = 8'h00;
    start(2);
    send(64, 1'b0);
    check(synd == '0 && !err, "R10", synd, '0);
    check(k_done == 0, "R4", 128'(k_done), '0);
    do_ack();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule